// File: doc/BRIEF.md
# Strap-Sampled General-Purpose I/O Port

This block is a register-controlled digital I/O port of 24 bit positions, of which the lower 11 are wired to pads and the upper 13 are reserved. Software reaches three registers over a simple synchronous write / combinational read bus: a pin-level register, a direction register in which a set bit means input, and an output polarity register. Pads are driven with an output value and an output enable, and pad inputs (which carry pull-ups, so an unconnected pin reads 1) are brought in through a two-flop synchronizer.

While reset is held, four strap pins are sampled continuously. The value present on the last clock edge of reset is kept as the host interface mode (SPI, UART or I2C) and a two-bit device address, and both stay fixed until the next reset. Once a mode is latched, the pins that mode's serial engine uses are handed to that engine: user direction and level writes to them are dropped, and their pad output and enable come from the engine's own drive inputs. The strap pins that still matter are kept as inputs. By default, outputs are active-low: a logical 1 in the level register drives the pad low unless the polarity bit for that pin is set.

Top module: `gpio_strap_port`

## Requirements
- R1: After reset, the direction register reads 0x7FF (all implemented pins inputs), the polarity register reads 0, and no pin has its output enable set unless its serial engine asks for it.
- R2: A pin under user control has pad_oe high when its direction bit is 0 and low when its direction bit is 1.
- R3: For a pin configured as an input, the level register (bus address 0) returns the pad level, so a floating pin that is pulled up reads 1.
- R4: For a user output pin, the level register reads back the value written to it. With polarity 0, the pad is driven to the inverse of that value.
- R5: The polarity register (bus address 2) reads back what was written to it in bits 10:0. A polarity bit of 1 makes the pad level equal to the written level bit.
- R6: Bits 23:11 read 0 in every register, ignore writes and never enable a pad output. Bus address 3 reads 0.
- R7: The mode is taken from the straps on the last reset edge. Strap bit 8 low gives SPI (code 0) with address 0. Bit 8 high with bit 9 low gives UART (code 1). Bits 8 and 9 both high give I2C (code 2). Outside SPI, the address is {pad 5, pad 1}.
- R8: strap_mode and strap_addr do not change after reset release, whatever the strap pins do.
- R9: Pins claimed by the latched mode (SPI: 1,2,3,5; UART: 0,3; I2C: 2,3,6) ignore user direction and level writes, so their direction reads 1. Their pad_oe and pad_out follow ifc_oe and ifc_out.
- R10: Strap pins 8 and 9 in every mode, and pins 1 and 5 outside SPI when not claimed, stay inputs. Direction writes to them are ignored and their pad_oe stays low.
- R11: A pad input change reaches the level register after exactly two clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; straps are sampled while low |
| bus_we | input | 1 | Write strobe, takes effect on the next clock edge |
| bus_addr | input | 2 | Register select: 0 level, 1 direction, 2 polarity |
| bus_wdata | input | 24 | Write data |
| bus_rdata | output | 24 | Read data for bus_addr, combinational |
| pad_in | input | 24 | Pad input levels |
| pad_out | output | 24 | Pad output levels |
| pad_oe | output | 24 | Pad output enables |
| ifc_out | input | 24 | Serial engine output levels for claimed pins |
| ifc_oe | input | 24 | Serial engine output enables for claimed pins |
| strap_mode | output | 2 | Latched host mode: 0 SPI, 1 UART, 2 I2C |
| strap_addr | output | 2 | Latched device address |

## Verification
Every one of the 16 combinations of the four strap pins is applied across a reset. This separates the SPI case, where the address straps must be ignored, from the two serial modes, where the address and the set of claimed pins differ. In each resulting mode, level patterns (all zeros, all ones, alternating bits and a walking one) are crossed with three polarity patterns. This shows whether inversion is applied per bit and whether claimed or strap pins leak into the user path. Input patterns are stepped one edge at a time to expose the synchronizer depth, and all-ones writes show whether any reserved bit is stored or driven.

// File: rtl/gpio_strap_pkg.sv
`timescale 1ns/1ps
// Package: shared register map and host-mode encoding for the strap GPIO port.
// Assumes a two-bit register address space.
package gpio_strap_pkg;
    localparam int REG_AW = 2;

    typedef enum logic [REG_AW-1:0] {
        REG_LEVEL = 2'd0,
        REG_DIR   = 2'd1,
        REG_POL   = 2'd2
    } reg_sel_e;

    typedef enum logic [1:0] {
        HOST_SPI  = 2'd0,
        HOST_UART = 2'd1,
        HOST_I2C  = 2'd2
    } host_mode_e;

    // Maps the two interface-select straps to a host mode.
    function automatic host_mode_e decode_host(input logic sel_a, input logic sel_b);
        if (!sel_a)
            return HOST_SPI;
        else if (sel_b)
            return HOST_I2C;
        else
            return HOST_UART;
    endfunction
endpackage

// File: rtl/gpio_pad_sync.sv
`timescale 1ns/1ps
// Module: two-stage synchronizer for pad inputs.
// Has no reset on purpose: it must keep running while reset is held so the
// strap pins can be sampled through it. Assumes inputs are level signals.
module gpio_pad_sync #(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;

    // Shift pad levels through two flops.
    always_ff @(posedge clk) begin
        meta_q <= d;
        q      <= meta_q;
    end
endmodule

// File: rtl/gpio_strap_latch.sv
`timescale 1ns/1ps
// Module: captures host mode and address from the straps while reset is low,
// and builds the masks of pins claimed by the serial engine or held as inputs.
// Assumes strap inputs are already synchronized.
module gpio_strap_latch
    import gpio_strap_pkg::*;
#(
    parameter int              PORT_W     = 24,
    parameter int              SEL_A_BIT  = 8,
    parameter int              SEL_B_BIT  = 9,
    parameter int              ADR0_BIT   = 1,
    parameter int              ADR1_BIT   = 5,
    parameter logic [PORT_W-1:0] SPI_CLAIM  = 24'h00002E,
    parameter logic [PORT_W-1:0] UART_CLAIM = 24'h000009,
    parameter logic [PORT_W-1:0] I2C_CLAIM  = 24'h00004C
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        straps,      // {adr1, adr0, sel_b, sel_a}
    output host_mode_e        mode,
    output logic [1:0]        addr,
    output logic [PORT_W-1:0] claim_mask,
    output logic [PORT_W-1:0] hold_mask
);
    // Track the straps during reset; freeze on release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode <= decode_host(straps[0], straps[1]);
            addr <= straps[0] ? straps[3:2] : 2'b00;
        end
    end

    // Select the pin set owned by the latched serial engine.
    always_comb begin
        case (mode)
            HOST_SPI:  claim_mask = SPI_CLAIM;
            HOST_UART: claim_mask = UART_CLAIM;
            HOST_I2C:  claim_mask = I2C_CLAIM;
            default:   claim_mask = '0;
        endcase
    end

    // Strap pins that must stay inputs, unless the engine owns them.
    always_comb begin
        logic [PORT_W-1:0] raw;
        raw = '0;
        raw[SEL_A_BIT] = 1'b1;
        raw[SEL_B_BIT] = 1'b1;
        if (mode != HOST_SPI) begin
            raw[ADR0_BIT] = 1'b1;
            raw[ADR1_BIT] = 1'b1;
        end
        hold_mask = raw & ~claim_mask;
    end
endmodule

// File: rtl/gpio_regfile.sv
`timescale 1ns/1ps
// Module: level, direction and polarity registers with masked writes and the
// read multiplexer. Assumes lock_mask marks the pins the user may not steer.
module gpio_regfile
    import gpio_strap_pkg::*;
#(
    parameter int PORT_W = 24,
    parameter int IMPL_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [REG_AW-1:0] addr,
    input  logic [PORT_W-1:0] wdata,
    output logic [PORT_W-1:0] rdata,
    input  logic [PORT_W-1:0] pin_sync,
    input  logic [PORT_W-1:0] lock_mask,
    output logic [PORT_W-1:0] dir_q,
    output logic [PORT_W-1:0] lvl_q,
    output logic [PORT_W-1:0] pol_q
);
    localparam logic [PORT_W-1:0] IMPL_MASK =
        {{(PORT_W-IMPL_W){1'b0}}, {IMPL_W{1'b1}}};

    logic [PORT_W-1:0] user_mask;
    assign user_mask = IMPL_MASK & ~lock_mask;

    // Register updates: reset to inputs, writes masked per register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q <= IMPL_MASK;
            lvl_q <= '0;
            pol_q <= '0;
        end else if (we) begin
            case (reg_sel_e'(addr))
                REG_LEVEL: lvl_q <= (lvl_q & ~user_mask) | (wdata & user_mask);
                REG_DIR:   dir_q <= (dir_q & ~user_mask) | (wdata & user_mask);
                REG_POL:   pol_q <= (pol_q & ~IMPL_MASK) | (wdata & IMPL_MASK);
                default:   ;
            endcase
        end
    end

    // Read mux: inputs show the pad, outputs show the stored level.
    always_comb begin
        case (reg_sel_e'(addr))
            REG_LEVEL: rdata = ((dir_q & pin_sync) | (~dir_q & lvl_q)) & IMPL_MASK;
            REG_DIR:   rdata = dir_q & IMPL_MASK;
            REG_POL:   rdata = pol_q & IMPL_MASK;
            default:   rdata = '0;
        endcase
    end
endmodule

// File: rtl/gpio_strap_port.sv
`timescale 1ns/1ps
// Module: top of the strap-sampled GPIO port. Ties the synchronizer, strap
// latch and register file together and drives the pads. Assumes the serial
// engines present ifc_out/ifc_oe for every pin and only claimed bits matter.
module gpio_strap_port
    import gpio_strap_pkg::*;
#(
    parameter int              PORT_W     = 24,
    parameter int              IMPL_W     = 11,
    parameter int              SEL_A_BIT  = 8,
    parameter int              SEL_B_BIT  = 9,
    parameter int              ADR0_BIT   = 1,
    parameter int              ADR1_BIT   = 5,
    parameter logic [PORT_W-1:0] SPI_CLAIM  = 24'h00002E,
    parameter logic [PORT_W-1:0] UART_CLAIM = 24'h000009,
    parameter logic [PORT_W-1:0] I2C_CLAIM  = 24'h00004C
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [1:0]        bus_addr,
    input  logic [PORT_W-1:0] bus_wdata,
    output logic [PORT_W-1:0] bus_rdata,
    input  logic [PORT_W-1:0] pad_in,
    output logic [PORT_W-1:0] pad_out,
    output logic [PORT_W-1:0] pad_oe,
    input  logic [PORT_W-1:0] ifc_out,
    input  logic [PORT_W-1:0] ifc_oe,
    output logic [1:0]        strap_mode,
    output logic [1:0]        strap_addr
);
    localparam logic [PORT_W-1:0] IMPL_MASK =
        {{(PORT_W-IMPL_W){1'b0}}, {IMPL_W{1'b1}}};

    logic [PORT_W-1:0] pin_sync;
    logic [PORT_W-1:0] claim_mask, hold_mask, user_mask;
    logic [PORT_W-1:0] dir_q, lvl_q, pol_q;
    host_mode_e        mode;

    gpio_pad_sync #(.W(PORT_W)) u_sync (
        .clk (clk),
        .d   (pad_in),
        .q   (pin_sync)
    );

    gpio_strap_latch #(
        .PORT_W(PORT_W), .SEL_A_BIT(SEL_A_BIT), .SEL_B_BIT(SEL_B_BIT),
        .ADR0_BIT(ADR0_BIT), .ADR1_BIT(ADR1_BIT),
        .SPI_CLAIM(SPI_CLAIM), .UART_CLAIM(UART_CLAIM), .I2C_CLAIM(I2C_CLAIM)
    ) u_strap (
        .clk        (clk),
        .rst_n      (rst_n),
        .straps     ({pin_sync[ADR1_BIT], pin_sync[ADR0_BIT],
                      pin_sync[SEL_B_BIT], pin_sync[SEL_A_BIT]}),
        .mode       (mode),
        .addr       (strap_addr),
        .claim_mask (claim_mask),
        .hold_mask  (hold_mask)
    );

    gpio_regfile #(.PORT_W(PORT_W), .IMPL_W(IMPL_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (bus_we),
        .addr      (bus_addr),
        .wdata     (bus_wdata),
        .rdata     (bus_rdata),
        .pin_sync  (pin_sync),
        .lock_mask (claim_mask | hold_mask),
        .dir_q     (dir_q),
        .lvl_q     (lvl_q),
        .pol_q     (pol_q)
    );

    assign strap_mode = mode;
    assign user_mask  = IMPL_MASK & ~(claim_mask | hold_mask);

    // Pad drive: user pins use active-low level with polarity flip; claimed
    // pins pass the engine's drive; held and reserved pins stay undriven.
    always_comb begin
        pad_oe  = (user_mask & ~dir_q) | (claim_mask & IMPL_MASK & ifc_oe);
        pad_out = (user_mask & ~(lvl_q ^ pol_q)) | (claim_mask & IMPL_MASK & ifc_out);
    end
endmodule

// File: rtl/gpio_strap_port_chk.sv
`timescale 1ns/1ps
// Module: assertion checker for gpio_strap_port, attached by bind below.
// Observes top-level ports only.
module gpio_strap_port_chk #(
    parameter int PORT_W    = 24,
    parameter int IMPL_W    = 11,
    parameter int SEL_A_BIT = 8,
    parameter int SEL_B_BIT = 9
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        bus_addr,
    input logic [PORT_W-1:0] bus_rdata,
    input logic [PORT_W-1:0] pad_oe,
    input logic [PORT_W-1:0] ifc_oe,
    input logic [1:0]        strap_mode,
    input logic [1:0]        strap_addr
);
    localparam logic [PORT_W-1:0] RSV_MASK = ~{{(PORT_W-IMPL_W){1'b0}}, {IMPL_W{1'b1}}};

    // R8: latched mode and address hold still once out of reset.
    a_r8_mode_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ($stable(strap_mode) && $stable(strap_addr)));

    // R7: SPI mode always carries address 0, and code 3 never appears.
    a_r7_spi_addr_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (strap_mode == 2'd0) |-> (strap_addr == 2'd0));
    a_r7_legal_mode: assert property (@(posedge clk) disable iff (!rst_n)
        strap_mode != 2'd3);

    // R6: reserved positions never driven and never read back.
    a_r6_rsv_oe_low: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_oe & RSV_MASK) == '0);
    a_r6_rsv_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        ((bus_rdata & RSV_MASK) == '0) && ((bus_addr != 2'd3) || (bus_rdata == '0)));

    // R10: interface-select straps are never outputs.
    a_r10_sel_straps_in: assert property (@(posedge clk) disable iff (!rst_n)
        !pad_oe[SEL_A_BIT] && !pad_oe[SEL_B_BIT]);

    // R1: first cycle out of reset, only engine-requested enables are set.
    a_r1_reset_inputs: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> ((pad_oe & ~ifc_oe) == '0));
endmodule

bind gpio_strap_port gpio_strap_port_chk #(
    .PORT_W(PORT_W), .IMPL_W(IMPL_W), .SEL_A_BIT(SEL_A_BIT), .SEL_B_BIT(SEL_B_BIT)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .bus_rdata  (bus_rdata),
    .pad_oe     (pad_oe),
    .ifc_oe     (ifc_oe),
    .strap_mode (strap_mode),
    .strap_addr (strap_addr)
);

// File: tb/gpio_strap_port_tb.sv
`timescale 1ns/1ps
// Bench: sweeps all strap combinations, then per mode sweeps level, polarity,
// direction and input patterns; expected values computed from the requirements.
module gpio_strap_port_tb;
    localparam logic [23:0] IMPL = 24'h0007FF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [23:0] bus_wdata = '0;
    logic [23:0] bus_rdata;
    logic [23:0] pad_in = 24'hFFFFFF;
    logic [23:0] pad_out, pad_oe;
    logic [23:0] ifc_out = '0, ifc_oe = '0;
    logic [1:0]  strap_mode, strap_addr;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    gpio_strap_port u_dut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .ifc_out(ifc_out), .ifc_oe(ifc_oe),
        .strap_mode(strap_mode), .strap_addr(strap_addr)
    );

    task automatic check(input string req, input logic [23:0] act, input logic [23:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [23:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [23:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    function automatic logic [23:0] claim_of(input int m);
        case (m)
            0:       return 24'h00002E;
            1:       return 24'h000009;
            default: return 24'h00004C;
        endcase
    endfunction

    function automatic logic [23:0] hold_of(input int m);
        logic [23:0] h;
        h = 24'h000300 | ((m != 0) ? 24'h000022 : 24'h0);
        return h & ~claim_of(m);
    endfunction

    initial begin
        #1_000_000;
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [23:0] r, claim, hold, user, prev;
        logic [23:0] pats [6];
        logic [23:0] pols [3];
        int em, ea;
        pats[0] = 24'h000; pats[1] = 24'h7FF; pats[2] = 24'h555;
        pats[3] = 24'h2AA; pats[4] = 24'hFFFFFF; pats[5] = 24'h0F3;
        pols[0] = 24'h000; pols[1] = 24'h7FF; pols[2] = 24'h5A5;

        for (int c = 0; c < 16; c++) begin
            // Apply straps and reset.
            ifc_oe = '0; ifc_out = '0;
            pad_in = 24'hFFFFFF;
            pad_in[8] = c[0]; pad_in[9] = c[1]; pad_in[1] = c[2]; pad_in[5] = c[3];
            rst_n = 1'b0;
            repeat (5) @(negedge clk);
            rst_n = 1'b1;
            em = !c[0] ? 0 : (c[1] ? 2 : 1);
            ea = c[0] ? {c[3], c[2]} : 0;
            claim = claim_of(em); hold = hold_of(em);
            user  = IMPL & ~(claim | hold);
            @(negedge clk);
            // R7: decode of the sampled straps.
            check("R7 mode", {22'd0, strap_mode}, 24'(em));
            check("R7 addr", {22'd0, strap_addr}, 24'(ea));
            // R1: reset state.
            rd(2'd1, r); check("R1 dir reset", r, IMPL);
            rd(2'd2, r); check("R1 pol reset", r, 24'h0);
            check("R1 oe reset", pad_oe, 24'h0);

            // R8: strap changes after release have no effect.
            pad_in = pad_in ^ 24'h000322;
            repeat (4) @(negedge clk);
            check("R8 mode frozen", {22'd0, strap_mode}, 24'(em));
            check("R8 addr frozen", {22'd0, strap_addr}, 24'(ea));
            pad_in = 24'hFFFFFF;
            repeat (3) @(negedge clk);
            // R3: floating pulled-up inputs read 1.
            rd(2'd0, r); check("R3 floating reads 1", r, IMPL);

            // R2/R9/R10: attempt to make every pin an output.
            wr(2'd1, 24'h000000);
            rd(2'd1, r); check("R9 R10 locked dir stays input", r, claim | hold);
            check("R2 oe follows dir", pad_oe, user);
            check("R10 held pins undriven", pad_oe & hold, 24'h0);
            ifc_oe = 24'hFFFFFF; ifc_out = 24'h5A5A5A;
            #1;
            check("R9 claimed oe from engine", pad_oe, user | claim);
            check("R9 claimed out from engine", pad_out & claim, 24'h5A5A5A & claim);
            ifc_oe = 24'h000000; ifc_out = 24'hA5A5A5;
            #1;
            check("R9 claimed oe engine off", pad_oe & claim, 24'h0);
            check("R9 claimed out follows", pad_out & claim, 24'hA5A5A5 & claim);

            // R4/R5: level and polarity sweep, incl. walking ones.
            for (int p = 0; p < 3; p++) begin
                wr(2'd2, pols[p]);
                rd(2'd2, r); check("R5 pol readback", r, pols[p] & IMPL);
                for (int k = 0; k < 17; k++) begin
                    logic [23:0] v;
                    v = (k < 6) ? pats[k] : (24'h1 << (k - 6));
                    wr(2'd0, v);
                    rd(2'd0, r);
                    check("R4 level readback", r, (v & user) | (pad_in & IMPL & ~user));
                    check("R4 R5 pad level", pad_out & user, ~(v ^ pols[p]) & user);
                end
            end

            // R3/R11: all inputs, pattern steps and sync latency.
            wr(2'd1, 24'hFFFFFF);
            for (int k = 0; k < 4; k++) begin
                prev = pad_in;
                pad_in = pats[k + 2] ^ 24'h00F00F;
                @(negedge clk);
                rd(2'd0, r); check("R11 one edge still old", r, prev & IMPL);
                @(negedge clk);
                rd(2'd0, r); check("R11 R3 two edges new", r, pad_in & IMPL);
            end
            pad_in = 24'hFFFFFF;
            repeat (3) @(negedge clk);

            // R6: reserved bits.
            wr(2'd2, 24'hFFFFFF);
            wr(2'd0, 24'hFFFFFF);
            wr(2'd1, 24'h000000);
            rd(2'd0, r); check("R6 level reserved", r & ~IMPL, 24'h0);
            rd(2'd1, r); check("R6 dir reserved", r & ~IMPL, 24'h0);
            rd(2'd2, r); check("R6 pol reserved", r, IMPL);
            rd(2'd3, r); check("R6 unused address", r, 24'h0);
            check("R6 reserved oe", pad_oe & ~IMPL, 24'h0);
        end

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule